// File: doc/BRIEF.md
# Four-Term Linear Address Generator

This block forms the linear address of a memory operand from four parts: a segment base, an optional base register value, an optional index register value scaled by 1, 2, 4 or 8, and a displacement that is either a sign-extended byte or a full 32-bit word. All four terms are added within a single clock. A carry-save compression tree reduces them to two vectors, and one carry-propagate adder finishes the sum.

The result is registered, so it appears one clock after the request. A request can be accepted on every clock, and a valid flag travels alongside the address. The sum wraps modulo 2^32 and no overflow is reported. Limit checks, paging, register reads and instruction decode are handled outside this block.

Top module: `lin_addr_gen`

## Requirements
- R1: While reset (`rst_n` low) is asserted, and on the first clock after it is released, `out_valid` is 0 and `lin_addr` is 0.
- R2: When `in_valid` is 1 on a rising edge, on the next edge `lin_addr` becomes seg_base + base term + index term + displacement term, truncated to 32 bits (modulo 2^32).
- R3: The index term is `idx_val` shifted left by `scale_code` (code 0,1,2,3 gives ×1,×2,×4,×8), with bits shifted beyond bit 31 lost.
- R4: When `base_en` is 0, the base term is zero whatever `base_val` holds.
- R5: When `idx_en` is 0, the index term is zero whatever `idx_val` and `scale_code` hold.
- R6: When `disp_wide` is 0, the displacement term is bits 7:0 of `disp`, sign-extended from bit 7, and bits 31:8 of `disp` are ignored. When `disp_wide` is 1, all 32 bits of `disp` are used.
- R7: `out_valid` on each edge equals the `in_valid` sampled on the previous edge. Back-to-back requests each produce a result on consecutive cycles.
- R8: When `in_valid` is 0, `lin_addr` holds its previous value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | A request is present |
| seg_base | input | 32 | Segment base address |
| base_val | input | 32 | Base register value |
| base_en | input | 1 | Include the base term |
| idx_val | input | 32 | Index register value |
| idx_en | input | 1 | Include the index term |
| scale_code | input | 2 | Index shift amount, 0 to 3 |
| disp | input | 32 | Displacement |
| disp_wide | input | 1 | 1: use the 32-bit displacement; 0: sign-extend bits 7:0 |
| out_valid | output | 1 | `lin_addr` holds a new result |
| lin_addr | output | 32 | Registered linear address |

## Verification
Every result is due exactly one rising edge after its request. The bench drives inputs on the falling edge and samples `lin_addr` and `out_valid` on the next falling edge, which falls between the capturing edge and the following one. Pipelined streams are checked one result per cycle, in the same order as the requests. A slot with `in_valid` low is checked for an unchanged address on the cycle after it. The bench's reference model uses native multiplication and a `$signed` cast rather than shifts and bit replication.

// File: rtl/lag_pkg.sv
package lag_pkg;
  localparam int unsigned AW = 32;
  localparam int unsigned SW = 2;
  localparam int unsigned DSHORT = 8;
  typedef logic [AW-1:0] addr_t;

  function automatic addr_t scale_idx(input addr_t v, input logic [SW-1:0] sc);
    return v << sc;
  endfunction

  function automatic addr_t ext_disp(input addr_t d, input logic wide);
    return wide ? d : {{(AW-DSHORT){d[DSHORT-1]}}, d[DSHORT-1:0]};
  endfunction
endpackage

// File: rtl/lag_terms.sv
module lag_terms
  import lag_pkg::*;
(
  input  addr_t          base_val,
  input  logic           base_en,
  input  addr_t          idx_val,
  input  logic           idx_en,
  input  logic [SW-1:0]  scale_code,
  input  addr_t          disp,
  input  logic           disp_wide,
  output addr_t          t_base,
  output addr_t          t_idx,
  output addr_t          t_disp
);
  assign t_base = base_en ? base_val : '0;
  assign t_idx  = idx_en ? scale_idx(idx_val, scale_code) : '0;
  assign t_disp = ext_disp(disp, disp_wide);
endmodule

// File: rtl/lag_csa.sv
module lag_csa
  import lag_pkg::*;
(
  input  addr_t a,
  input  addr_t b,
  input  addr_t c,
  output addr_t s,
  output addr_t k
);
  addr_t maj;
  assign s   = a ^ b ^ c;
  assign maj = (a & b) | (a & c) | (b & c);
  assign k   = {maj[AW-2:0], 1'b0};
endmodule

// File: rtl/lin_addr_gen.sv
module lin_addr_gen
  import lag_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  logic          in_valid,
  input  logic [31:0]   seg_base,
  input  logic [31:0]   base_val,
  input  logic          base_en,
  input  logic [31:0]   idx_val,
  input  logic          idx_en,
  input  logic [1:0]    scale_code,
  input  logic [31:0]   disp,
  input  logic          disp_wide,
  output logic          out_valid,
  output logic [31:0]   lin_addr
);
  addr_t t_base, t_idx, t_disp;
  addr_t s1, k1, s2, k2;
  addr_t sum_next;

  lag_terms u_terms (
    .base_val(base_val), .base_en(base_en), .idx_val(idx_val), .idx_en(idx_en),
    .scale_code(scale_code), .disp(disp), .disp_wide(disp_wide),
    .t_base(t_base), .t_idx(t_idx), .t_disp(t_disp)
  );

  lag_csa u_csa0 (.a(seg_base), .b(t_base), .c(t_idx), .s(s1), .k(k1));
  lag_csa u_csa1 (.a(s1), .b(k1), .c(t_disp), .s(s2), .k(k2));

  assign sum_next = s2 + k2;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      lin_addr  <= '0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) lin_addr <= sum_next;
    end
  end

  AST_TREE_MATCHES_SUM: assert property (@(posedge clk) disable iff (!rst_n)
    sum_next == seg_base + t_base + t_idx + t_disp); // R2
  AST_IDX_OFF_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    !idx_en |-> t_idx == '0); // R5
  AST_BASE_OFF_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    !base_en |-> t_base == '0); // R4
  AST_SHORT_DISP_SIGN: assert property (@(posedge clk) disable iff (!rst_n)
    !disp_wide |-> (t_disp[31:8] == {24{disp[7]}})); // R6
  AST_VALID_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid); // R7
  AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> $stable(lin_addr)); // R8
endmodule

// File: tb/sim_lin_addr_gen.sv
`timescale 1ns/1ps
module sim_lin_addr_gen;
  logic clk = 0, rst_n = 0, in_valid = 0;
  logic [31:0] seg_base = 0, base_val = 0, idx_val = 0, disp = 0;
  logic base_en = 0, idx_en = 0, disp_wide = 0;
  logic [1:0] scale_code = 0;
  logic out_valid;
  logic [31:0] lin_addr;
  int n_chk = 0, n_bad = 0;

  always #5 clk = ~clk;

  lin_addr_gen u0 (.*);

  function automatic logic [31:0] model(input logic [31:0] sb, bv, input logic be,
      input logic [31:0] iv, input logic ie, input logic [1:0] sc,
      input logic [31:0] d, input logic dw);
    longint acc;
    acc = longint'(sb);
    if (be) acc += longint'(bv);
    if (ie) acc += longint'(iv) * (longint'(1) << sc);
    if (dw) acc += longint'(d);
    else acc += longint'($signed(d[7:0]));
    return acc[31:0];
  endfunction

  task automatic check(input string req, input logic [31:0] act, exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic drive(input logic [31:0] sb, bv, input logic be,
      input logic [31:0] iv, input logic ie, input logic [1:0] sc,
      input logic [31:0] d, input logic dw);
    seg_base = sb; base_val = bv; base_en = be; idx_val = iv; idx_en = ie;
    scale_code = sc; disp = d; disp_wide = dw; in_valid = 1;
  endtask

  task automatic one(input string req, input logic [31:0] sb, bv, input logic be,
      input logic [31:0] iv, input logic ie, input logic [1:0] sc,
      input logic [31:0] d, input logic dw);
    @(negedge clk);
    drive(sb, bv, be, iv, ie, sc, d, dw);
    @(negedge clk);
    in_valid = 0;
    check(req, lin_addr, model(sb, bv, be, iv, ie, sc, d, dw));
    check({req, " valid"}, {31'b0, out_valid}, 32'd1);
  endtask

  task automatic t_reset;
    @(negedge clk);
    check("R1 addr", lin_addr, 0);
    check("R1 valid", {31'b0, out_valid}, 0);
    rst_n = 1;
    @(negedge clk);
    check("R1 valid after", {31'b0, out_valid}, 0);
  endtask

  task automatic t_scales;
    for (int s = 0; s < 4; s++)
      one("R3 scale", 32'h1000, 32'h20, 1, 32'h0000_0123, 1, 2'(s), 32'h4, 1);
    one("R3 shift out", 32'h0, 32'h0, 0, 32'hF000_0001, 1, 2'd3, 32'h0, 1);
  endtask

  task automatic t_enables;
    one("R4 base off", 32'h100, 32'hDEAD_BEEF, 0, 32'h10, 1, 2'd1, 32'h0, 1);
    one("R5 idx off", 32'h100, 32'h40, 1, 32'hFFFF_FFFF, 0, 2'd3, 32'h0, 1);
  endtask

  task automatic t_disp;
    one("R6 neg byte", 32'h2000, 32'h0, 0, 32'h0, 0, 2'd0, 32'h1234_56F0, 0);
    one("R6 pos byte", 32'h2000, 32'h0, 0, 32'h0, 0, 2'd0, 32'hFFFF_FF7F, 0);
    one("R6 wide", 32'h2000, 32'h0, 0, 32'h0, 0, 2'd0, 32'h8000_0000, 1);
  endtask

  task automatic t_full;
    one("R2 full", 32'hFFFF_0000, 32'h0001_2345, 1, 32'h0000_8000, 1, 2'd2, 32'hFFFF_FFF0, 1);
    one("R2 wrap", 32'hFFFF_FFFF, 32'hFFFF_FFFF, 1, 32'hFFFF_FFFF, 1, 2'd3, 32'h0000_0080, 0);
  endtask

  task automatic t_stream;
    logic [31:0] e [4];
    for (int i = 0; i < 4; i++)
      e[i] = model(32'h100*i, 32'h11*i, 1, 32'h3+i, 1, 2'(i), 32'h80+i, 0);
    @(negedge clk);
    for (int i = 0; i < 4; i++) begin
      drive(32'h100*i, 32'h11*i, 1, 32'h3+i, 1, 2'(i), 32'h80+i, 0);
      @(negedge clk);
      check("R7 stream", lin_addr, e[i]);
      check("R7 valid", {31'b0, out_valid}, 1);
    end
    in_valid = 0;
    seg_base = 32'h5555_5555;
    @(negedge clk);
    check("R7 valid drop", {31'b0, out_valid}, 0);
    check("R8 hold", lin_addr, e[3]);
    @(negedge clk);
    check("R8 hold2", lin_addr, e[3]);
  endtask

  initial begin
    fork
      begin
        t_reset; t_scales; t_enables; t_disp; t_full; t_stream;
      end
      begin
        repeat (5000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog actual=timeout expected=done");
      end
    join_any
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule